// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between the load/store stage of a processor and a data memory that is 32 bits wide and addressed in bytes. A request gives a byte address, a size (one byte or one full word) and a direction. One clock later the block drives the memory port with a word address, four byte-lane strobes and store data already steered into the correct lanes. Lanes are numbered big-endian: byte offset 0 is the most significant byte of the word.

A read reaches the memory one cycle after the request. The memory returns its word one cycle after that. The block then takes the addressed byte out of the returned word and sign-extends it, or passes a full word through unchanged.

Word accesses must be aligned. A word request whose two low address bits are not zero does not reach the memory. Instead it raises a one-cycle misalignment flag. Byte requests are never misaligned.

Top module: `byte_lane_aligner`

## Requirements
- R1: For each accepted request, memAddr equals reqAddr with bits [1:0] cleared. memValid is high, and memWrite equals reqStore, in the cycle after the request.
- R2: An accepted byte access asserts exactly one strobe, memByteEn[3 - off], where off = reqAddr[1:0]. Offset 0 therefore selects memByteEn[3], which covers bits [31:24], and offset 3 selects memByteEn[0], which covers bits [7:0].
- R3: A byte store copies reqWdata[7:0] into all four lanes of memWdata. The single strobe picks which lane memory keeps.
- R4: An aligned word access asserts all four strobes (4'b1111). A word store drives reqWdata unchanged on memWdata.
- R5: A word request with reqAddr[1:0] != 0 raises misaligned for one cycle in the cycle after the request. In that cycle memValid is low and memByteEn is 4'b0000, and no loadValid follows.
- R6: loadValid rises two cycles after an accepted read request, which is one cycle after memValid with memWrite low. For a byte read, loadData is the byte in bits [(3-off)*8 +: 8] of memRdata, sign-extended to 32 bits.
- R7: For an aligned word read, loadData equals memRdata.
- R8: While rstN is low, and after it, until a request arrives, memValid, misaligned and loadValid are low and memByteEn is 4'b0000.
- R9: A cycle with reqValid low produces memValid low and memByteEn 4'b0000 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqWord | input | 1 | 1 = full word, 0 = single byte |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Store data from register |
| memRdata | input | 32 | Word returned by memory, one cycle after a read |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 32 | Word-aligned memory address |
| memByteEn | output | 4 | Lane strobes, bit 3 = bits [31:24] |
| memWdata | output | 32 | Lane-steered store data |
| misaligned | output | 1 | Misaligned word request was dropped |
| loadValid | output | 1 | loadData holds a load result |
| loadData | output | 32 | Extended or full load result |

## Verification
The assertions assume that memRdata is the answer to the read that was on the port in the previous cycle. They also assume that reqAddr and the size bits are stable at the clock edge where reqValid is sampled. The bench meets both conditions. Its memory model registers each read on the edge where memValid is sampled. Its driver changes every request input only at the falling edge, one request per cycle, with idle cycles mixed in. It covers every byte offset, aligned and misaligned words, and reads that follow writes to the same word.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  parameter int BYTE_W = 8;
  parameter int LANES  = 4;
  parameter int DATA_W = BYTE_W * LANES;
  parameter int ADDR_W = 32;
  parameter int OFS_W  = $clog2(LANES);

  // Strobes from control to datapath for the memory-side stage
  typedef struct packed {
    logic             valid;
    logic             write;
    logic             wordSize;
    logic             misal;
    logic [OFS_W-1:0] lane;
  } reqCtl_t;

  // Strobes for the load-return stage
  typedef struct packed {
    logic             valid;
    logic             wordSize;
    logic [OFS_W-1:0] lane;
  } ldCtl_t;
endpackage

// File: rtl/aligner_ctrl.sv
module aligner_ctrl
  import aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic             reqWord,
  input  logic [OFS_W-1:0] reqOfs,
  output reqCtl_t          reqCtl,
  output ldCtl_t           ldCtl
);
  logic badAlign;
  assign badAlign = reqValid && reqWord && (reqOfs != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqCtl <= '0;
      ldCtl  <= '0;
    end else begin
      reqCtl.valid    <= reqValid && !badAlign;
      reqCtl.misal    <= badAlign;
      reqCtl.write    <= reqStore;
      reqCtl.wordSize <= reqWord;
      reqCtl.lane     <= reqOfs;
      ldCtl.valid     <= reqCtl.valid && !reqCtl.write;
      ldCtl.wordSize  <= reqCtl.wordSize;
      ldCtl.lane      <= reqCtl.lane;
    end
  end
endmodule

// File: rtl/aligner_dp.sv
module aligner_dp
  import aligner_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  reqCtl_t           reqCtl,
  input  ldCtl_t            ldCtl,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BYTE_W-1:0] rdLane [LANES];
  logic [BYTE_W-1:0] pickByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (reqValid) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
    end
  end

  assign memAddr = {addrQ[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  // Lane i (offset i) lives in bits [(LANES-1-i)*BYTE_W +: BYTE_W]
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memByteEn[LANES-1-i] = reqCtl.valid &&
                                  (reqCtl.wordSize || (reqCtl.lane == OFS_W'(i)));
    assign rdLane[i] = memRdata[(LANES-1-i)*BYTE_W +: BYTE_W];
  end

  assign memWdata = reqCtl.wordSize ? dataQ : {LANES{dataQ[BYTE_W-1:0]}};

  assign pickByte = rdLane[ldCtl.lane];

  always_comb begin
    if (!ldCtl.valid)
      loadData = '0;
    else if (ldCtl.wordSize)
      loadData = memRdata;
    else
      loadData = {{(DATA_W-BYTE_W){pickByte[BYTE_W-1]}}, pickByte};
  end
endmodule

// File: rtl/byte_lane_aligner.sv
module byte_lane_aligner
  import aligner_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic              misaligned,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);
  reqCtl_t reqCtl;
  ldCtl_t  ldCtl;

  aligner_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqWord(reqWord), .reqOfs(reqAddr[OFS_W-1:0]),
    .reqCtl(reqCtl), .ldCtl(ldCtl)
  );

  aligner_dp dp_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memRdata(memRdata), .reqCtl(reqCtl), .ldCtl(ldCtl),
    .memAddr(memAddr), .memByteEn(memByteEn), .memWdata(memWdata),
    .loadData(loadData)
  );

  assign memValid   = reqCtl.valid;
  assign memWrite   = reqCtl.valid && reqCtl.write;
  assign misaligned = reqCtl.misal;
  assign loadValid  = ldCtl.valid;
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWord,
  input logic [31:0] reqAddr,
  input logic        memValid,
  input logic        memWrite,
  input logic [31:0] memAddr,
  input logic [3:0]  memByteEn,
  input logic [31:0] memWdata,
  input logic        misaligned,
  input logic        loadValid,
  input logic [31:0] loadData
);
  assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memAddr[1:0] == 2'b00);

  assert_strobe_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memByteEn == 4'hF || $countones(memByteEn) == 1));

  assert_byte_copies_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && memByteEn != 4'hF) |->
      (memWdata[31:24] == memWdata[7:0] && memWdata[23:16] == memWdata[7:0] &&
       memWdata[15:8] == memWdata[7:0]));

  assert_misal_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (!memValid && memByteEn == 4'h0));

  assert_misal_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWord && reqAddr[1:0] != 2'b00) |=> misaligned);

  assert_load_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memValid && !memWrite));

  assert_byte_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(memByteEn) != 4'hF) |-> loadData[31:8] == {24{loadData[7]}});

  assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> memByteEn == 4'h0);
endmodule

bind byte_lane_aligner aligner_checker chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
  .reqAddr(reqAddr), .memValid(memValid), .memWrite(memWrite),
  .memAddr(memAddr), .memByteEn(memByteEn), .memWdata(memWdata),
  .misaligned(misaligned), .loadValid(loadValid), .loadData(loadData)
);

// File: tb/byte_lane_aligner_tb_top.sv
module byte_lane_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqWord = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [31:0] memRdata = '0;
  logic        memValid, memWrite, misaligned, loadValid;
  logic [31:0] memAddr, memWdata, loadData;
  logic [3:0]  memByteEn;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic        v;
    logic        w;
    logic        mis;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        ldv;
    logic [31:0] ldd;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  logic [31:0] shadow [16];
  logic [31:0] memArr [16];

  always #10 clk = ~clk;

  byte_lane_aligner dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memRdata(memRdata), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memByteEn(memByteEn), .memWdata(memWdata),
    .misaligned(misaligned), .loadValid(loadValid), .loadData(loadData)
  );

  function automatic logic [31:0] seedWord(int i);
    return 32'h8F3A_C47B + (i * 32'h1320_0D91);
  endfunction

  // Memory model: byteEn bit k covers bits [k*8 +: 8]; read data one cycle later
  always @(posedge clk) begin
    if (memValid) begin
      if (memWrite) begin
        for (int k = 0; k < 4; k++)
          if (memByteEn[k]) memArr[memAddr[5:2]][k*8 +: 8] <= memWdata[k*8 +: 8];
      end else begin
        memRdata <= memArr[memAddr[5:2]];
      end
    end
  end

  task automatic check(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic v, input logic st, input logic wd,
                       input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    logic [7:0] b;
    @(negedge clk);
    reqValid = v; reqStore = st; reqWord = wd; reqAddr = a; reqWdata = d;
    e = '0;
    e.mis  = v && wd && (a[1:0] != 2'b00);
    e.v    = v && !e.mis;
    e.w    = st;
    e.addr = {a[31:2], 2'b00};
    e.be   = !e.v ? 4'h0 : (wd ? 4'hF : (4'b1000 >> a[1:0]));
    e.wd   = wd ? d : {4{d[7:0]}};
    e.ldv  = e.v && !st;
    if (e.ldv) begin
      b = shadow[a[5:2]][(3 - a[1:0])*8 +: 8];
      e.ldd = wd ? shadow[a[5:2]] : {{24{b[7]}}, b};
    end
    if (e.v && st)
      for (int k = 0; k < 4; k++)
        if (e.be[k]) shadow[a[5:2]][k*8 +: 8] = e.wd[k*8 +: 8];
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: sample 5 ns after each rising edge
  initial begin
    exp_t  e;
    exp_t  prev;
    string t;
    string pt;
    prev = '0;
    pt = "";
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " valid"}, memValid == e.v, 32'(memValid), 32'(e.v));
        check({t, " misaligned"}, misaligned == e.mis, 32'(misaligned), 32'(e.mis));
        check({t, " strobes"}, memByteEn == e.be, 32'(memByteEn), 32'(e.be));
        if (e.v) begin
          check({t, " R1 addr"}, memAddr == e.addr, memAddr, e.addr);
          check({t, " R1 write"}, memWrite == e.w, 32'(memWrite), 32'(e.w));
          if (e.w) check({t, " wdata"}, memWdata == e.wd, memWdata, e.wd);
        end
        check({pt, " R6 loadValid"}, loadValid == prev.ldv, 32'(loadValid), 32'(prev.ldv));
        if (prev.ldv)
          check({pt, " loadData"}, loadData == prev.ldd, loadData, prev.ldd);
        prev = e;
        pt = t;
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      shadow[i] = seedWord(i);
      memArr[i] = seedWord(i);
    end
    repeat (3) @(negedge clk);
    check("R8 reset quiet", !memValid && !misaligned && !loadValid && memByteEn == 4'h0,
          {28'h0, memByteEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 after reset", !memValid && !loadValid && memByteEn == 4'h0,
          {28'h0, memByteEn}, 32'h0);
    // R2 R3 byte stores at each offset of word 2
    for (int o = 0; o < 4; o++)
      doReq(1, 1, 0, 32'h0000_0008 + o, 32'h1234_5600 + 32'(o * 8'h31), "R3 byte store");
    doReq(0, 0, 0, 32'h0, 32'h0, "R9 idle");
    // R4 word store then word read
    doReq(1, 1, 1, 32'h0000_0010, 32'hCAFE_F00D, "R4 word store");
    doReq(1, 0, 1, 32'h0000_0010, 32'h0, "R7 word load");
    // R6 byte reads of written word and seeded words
    for (int o = 0; o < 4; o++)
      doReq(1, 0, 0, 32'h0000_0008 + o, 32'h0, "R6 byte load");
    for (int o = 0; o < 4; o++)
      doReq(1, 0, 0, 32'h0000_0014 + o, 32'h0, "R6 byte load seed");
    doReq(1, 0, 0, 32'h0000_0010, 32'h0, "R2 byte load off0");
    // R5 misaligned word accesses
    for (int o = 1; o < 4; o++) begin
      doReq(1, 1, 1, 32'h0000_0020 + o, 32'hDEAD_BEEF, "R5 misaligned store");
      doReq(1, 0, 1, 32'h0000_0024 + o, 32'h0, "R5 misaligned load");
    end
    doReq(1, 0, 1, 32'h0000_0020, 32'h0, "R5 untouched word");
    doReq(1, 0, 1, 32'h1234_5674, 32'h0, "R1 high addr load");
    doReq(0, 1, 1, 32'h0000_0031, 32'h0, "R9 idle junk");
    doReq(1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0080, "R2 byte store off3");
    doReq(1, 0, 0, 32'hFFFF_FFFF, 32'h0, "R6 byte load neg");
    doReq(1, 0, 1, 32'hFFFF_FFFC, 32'h0, "R7 word load back");
    for (int i = 0; i < 3; i++) doReq(0, 0, 0, 32'h0, 32'h0, "R9 drain");
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule